// File: doc/BRIEF.md
# Debug vector-catch register access gate

This block decides the fate of one system-register access aimed at a 32-bit-mode debug vector-catch control register, and holds that register's value. Each request carries its five encoding fields, a read/write flag, the exception level it comes from, and the configuration of the machine:
- whether the level-1 state can run 32-bit code;
- the nested-virtualisation trap bit;
- whether a monitor level (level 3) exists;
- the monitor's debug-access trap bit;
- two secure-debug-disable conditions.

The block gives exactly one outcome for each request that matches the register. The outcome is one of three: perform the access, raise an undefined-instruction exception, or trap to a named higher level with an exception class code.

The outcome is chosen by a fixed priority. First, a lower level that cannot run 32-bit code makes every access undefined. After that, the rules depend on the requesting level. Level 0 is always undefined. Level 1 either traps to level 2 or is undefined. Level 2 may be undefined, may trap to level 3, or may proceed. Level 3 always proceeds.

Allowed reads return the stored 64-bit value. Allowed writes replace it at the next clock edge, and only the low 32 bits are kept. The result comes out one cycle after the request, from a two-state machine:
- ST_IDLE moves to ST_RESPOND when a matching request arrives.
- ST_RESPOND goes back to ST_IDLE unless another matching request arrives in the same cycle.
- A request that does not match the register's encoding leaves the machine in ST_IDLE or returns it there.

Taking the exception itself is left to the logic downstream.

Top module: `vc_sysreg_gate`

## Requirements
- R1: Only a valid request with op0=2'b10, op1=3'b100, CRn=4'b0000, CRm=4'b0111, op2=3'b000 is answered. Any other encoding raises no response and leaves the stored value unchanged.
- R2: When cfg_aa32_ok is 0, every matching access, from any level, gets outcome undefined.
- R3: A matching access from level 0 (req_el=0) gets outcome undefined.
- R4: From level 1, a matching access traps to level 2 with class 8'h18 when cfg_nv_trap is 1. Otherwise it is undefined.
- R5: From level 2, when cfg_has_mon=1, cfg_tda=1 and cfg_sdd_prio=1, the outcome is undefined.
- R6: Otherwise, from level 2 with cfg_has_mon=1 and cfg_tda=1, the outcome is undefined if cfg_sdd_undef=1. If it is 0, the access traps to level 3 with class 8'h18.
- R7: All other level-2 accesses, and every level-3 access, get outcome access. A read then returns the stored value on rsp_rdata.
- R8: A write changes the stored value only when its outcome is access, and the new value is seen from the next request on. Bits 63:32 of the stored value always read as zero.
- R9: The response comes one clock after the request and rsp_valid is high for that single cycle. rsp_kind is coded 2'b00 access, 2'b01 undefined, 2'b10 trap. rsp_target and rsp_class are zero unless the outcome is trap. rsp_rdata is zero except for an allowed read.
- R10: After reset, rsp_valid is 0 and the stored value is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request present this cycle |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| req_write | input | 1 | 1 for write, 0 for read |
| req_el | input | 2 | Exception level of the requester |
| req_wdata | input | 64 | Write data |
| cfg_aa32_ok | input | 1 | Level 1 can run 32-bit code |
| cfg_nv_trap | input | 1 | Nested-virtualisation trap bit |
| cfg_has_mon | input | 1 | Level 3 exists |
| cfg_tda | input | 1 | Monitor debug-access trap bit |
| cfg_sdd_prio | input | 1 | Secure-debug-disable priority undefined condition |
| cfg_sdd_undef | input | 1 | Secure-debug-disable undefined condition |
| rsp_valid | output | 1 | Response present |
| rsp_kind | output | 2 | Outcome code |
| rsp_target | output | 2 | Trap target level |
| rsp_class | output | 8 | Trap exception class |
| rsp_rdata | output | 64 | Read data |

## Verification
Every combination of requesting level and the six configuration bits is applied, once as a write and once as a read. The write carries a fresh value with nonzero upper bits. Outcomes that allow the access are therefore told apart from blocked ones by what the following read returns, and the same read shows that the upper half is dropped. Each single-bit corruption of the encoding is then sent as a level-3 write, which would always succeed if it matched. This shows that a near-miss encoding produces neither a response nor a change to the stored value.

// File: rtl/vc_pkg.sv
package vc_pkg;

    localparam int OP0_W = 2;
    localparam int OP1_W = 3;
    localparam int CRN_W = 4;
    localparam int CRM_W = 4;
    localparam int OP2_W = 3;
    localparam int EL_W  = 2;
    localparam int CLS_W = 8;

    localparam logic [OP0_W-1:0] ENC_OP0 = 2'b10;
    localparam logic [OP1_W-1:0] ENC_OP1 = 3'b100;
    localparam logic [CRN_W-1:0] ENC_CRN = 4'b0000;
    localparam logic [CRM_W-1:0] ENC_CRM = 4'b0111;
    localparam logic [OP2_W-1:0] ENC_OP2 = 3'b000;

    localparam logic [CLS_W-1:0] DBG_TRAP_CLASS = 8'h18;

    localparam logic [EL_W-1:0] LVL0 = 2'd0;
    localparam logic [EL_W-1:0] LVL1 = 2'd1;
    localparam logic [EL_W-1:0] LVL2 = 2'd2;
    localparam logic [EL_W-1:0] LVL3 = 2'd3;

    typedef enum logic [1:0] {
        VC_ACCESS = 2'b00,
        VC_UNDEF  = 2'b01,
        VC_TRAP   = 2'b10
    } vc_kind_e;

    typedef enum logic {
        ST_IDLE,
        ST_RESPOND
    } vc_state_e;

    typedef struct packed {
        vc_kind_e               kind;
        logic [EL_W-1:0]        target;
        logic [CLS_W-1:0]       cls;
    } vc_outcome_t;

endpackage

// File: rtl/vc_enc_match.sv
module vc_enc_match
    import vc_pkg::*;
#(
    parameter logic [OP0_W-1:0] M_OP0 = ENC_OP0,
    parameter logic [OP1_W-1:0] M_OP1 = ENC_OP1,
    parameter logic [CRN_W-1:0] M_CRN = ENC_CRN,
    parameter logic [CRM_W-1:0] M_CRM = ENC_CRM,
    parameter logic [OP2_W-1:0] M_OP2 = ENC_OP2
) (
    input  logic [OP0_W-1:0] op0,
    input  logic [OP1_W-1:0] op1,
    input  logic [CRN_W-1:0] crn,
    input  logic [CRM_W-1:0] crm,
    input  logic [OP2_W-1:0] op2,
    output logic             hit
);
    localparam int ENC_W = OP0_W + OP1_W + CRN_W + CRM_W + OP2_W;
    localparam logic [ENC_W-1:0] KEY = {M_OP0, M_OP1, M_CRN, M_CRM, M_OP2};

    logic [ENC_W-1:0] enc;
    logic [ENC_W-1:0] diff;

    assign enc = {op0, op1, crn, crm, op2};

    for (genvar g = 0; g < ENC_W; g++) begin : g_bit
        assign diff[g] = enc[g] ^ KEY[g];
    end

    assign hit = ~|diff;
endmodule

// File: rtl/vc_route.sv
module vc_route
    import vc_pkg::*;
#(
    parameter logic [CLS_W-1:0] TRAP_CLASS = DBG_TRAP_CLASS
) (
    input  logic [EL_W-1:0] el,
    input  logic            aa32_ok,
    input  logic            nv_trap,
    input  logic            has_mon,
    input  logic            tda,
    input  logic            sdd_prio,
    input  logic            sdd_undef,
    output vc_outcome_t     outcome
);
    vc_outcome_t undef_o;
    vc_outcome_t access_o;
    vc_outcome_t trap2_o;
    vc_outcome_t trap3_o;
    logic        mon_trap;

    assign undef_o  = '{kind: VC_UNDEF,  target: '0,   cls: '0};
    assign access_o = '{kind: VC_ACCESS, target: '0,   cls: '0};
    assign trap2_o  = '{kind: VC_TRAP,   target: LVL2, cls: TRAP_CLASS};
    assign trap3_o  = '{kind: VC_TRAP,   target: LVL3, cls: TRAP_CLASS};
    assign mon_trap = has_mon & tda;

    always_comb begin
        outcome = undef_o;
        if (!aa32_ok) begin
            outcome = undef_o;
        end else begin
            unique case (el)
                LVL0: outcome = undef_o;
                LVL1: outcome = nv_trap ? trap2_o : undef_o;
                LVL2: begin
                    if (mon_trap && sdd_prio) begin
                        outcome = undef_o;
                    end else if (mon_trap) begin
                        outcome = sdd_undef ? undef_o : trap3_o;
                    end else begin
                        outcome = access_o;
                    end
                end
                LVL3: outcome = access_o;
                default: outcome = undef_o;
            endcase
        end
    end
endmodule

// File: rtl/vc_store.sv
module vc_store #(
    parameter int DATA_W  = 64,
    parameter int STORE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [DATA_W-1:0] KEEP = {{(DATA_W-STORE_W){1'b0}}, {STORE_W{1'b1}}};

    logic [DATA_W-1:0] value_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value_q <= '0;
        end else if (we) begin
            value_q <= wdata & KEEP;
        end
    end

    assign rdata = value_q & KEEP;
endmodule

// File: rtl/vc_sysreg_gate.sv
module vc_sysreg_gate
    import vc_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int STORE_W = 32,
    parameter logic [CLS_W-1:0] TRAP_CLASS = DBG_TRAP_CLASS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [OP0_W-1:0]  req_op0,
    input  logic [OP1_W-1:0]  req_op1,
    input  logic [CRN_W-1:0]  req_crn,
    input  logic [CRM_W-1:0]  req_crm,
    input  logic [OP2_W-1:0]  req_op2,
    input  logic              req_write,
    input  logic [EL_W-1:0]   req_el,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              cfg_aa32_ok,
    input  logic              cfg_nv_trap,
    input  logic              cfg_has_mon,
    input  logic              cfg_tda,
    input  logic              cfg_sdd_prio,
    input  logic              cfg_sdd_undef,
    output logic              rsp_valid,
    output logic [1:0]        rsp_kind,
    output logic [EL_W-1:0]   rsp_target,
    output logic [CLS_W-1:0]  rsp_class,
    output logic [DATA_W-1:0] rsp_rdata
);
    logic              enc_hit;
    logic              take;
    logic              store_we;
    logic [DATA_W-1:0] store_rdata;
    vc_outcome_t       route_o;
    vc_outcome_t       out_q;
    logic [DATA_W-1:0] rdata_q;
    vc_state_e         state_q;
    vc_state_e         state_d;

    vc_enc_match u_match (
        .op0 (req_op0),
        .op1 (req_op1),
        .crn (req_crn),
        .crm (req_crm),
        .op2 (req_op2),
        .hit (enc_hit)
    );

    vc_route #(.TRAP_CLASS(TRAP_CLASS)) u_route (
        .el        (req_el),
        .aa32_ok   (cfg_aa32_ok),
        .nv_trap   (cfg_nv_trap),
        .has_mon   (cfg_has_mon),
        .tda       (cfg_tda),
        .sdd_prio  (cfg_sdd_prio),
        .sdd_undef (cfg_sdd_undef),
        .outcome   (route_o)
    );

    assign take     = req_valid & enc_hit;
    assign store_we = take & req_write & (route_o.kind == VC_ACCESS);

    vc_store #(.DATA_W(DATA_W), .STORE_W(STORE_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (store_we),
        .wdata (req_wdata),
        .rdata (store_rdata)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = take ? ST_RESPOND : ST_IDLE;
            ST_RESPOND: state_d = take ? ST_RESPOND : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q   <= '{kind: VC_ACCESS, target: '0, cls: '0};
            rdata_q <= '0;
        end else if (take) begin
            out_q <= route_o;
            if (!req_write && route_o.kind == VC_ACCESS) begin
                rdata_q <= store_rdata;
            end else begin
                rdata_q <= '0;
            end
        end
    end

    always_comb begin
        rsp_valid  = 1'b0;
        rsp_kind   = VC_ACCESS;
        rsp_target = '0;
        rsp_class  = '0;
        rsp_rdata  = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RESPOND: begin
                rsp_valid  = 1'b1;
                rsp_kind   = out_q.kind;
                rsp_target = out_q.target;
                rsp_class  = out_q.cls;
                rsp_rdata  = rdata_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/vc_sysreg_gate_chk.sv
module vc_sysreg_gate_chk
    import vc_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [1:0]  req_op0,
    input logic [2:0]  req_op1,
    input logic [3:0]  req_crn,
    input logic [3:0]  req_crm,
    input logic [2:0]  req_op2,
    input logic [1:0]  req_el,
    input logic        cfg_aa32_ok,
    input logic        cfg_nv_trap,
    input logic        cfg_has_mon,
    input logic        cfg_tda,
    input logic        cfg_sdd_prio,
    input logic        cfg_sdd_undef,
    input logic        rsp_valid,
    input logic [1:0]  rsp_kind,
    input logic [1:0]  rsp_target,
    input logic [7:0]  rsp_class,
    input logic [63:0] rsp_rdata
);
    logic sel;
    assign sel = req_valid && req_op0 == 2'b10 && req_op1 == 3'b100 &&
                 req_crn == 4'b0000 && req_crm == 4'b0111 && req_op2 == 3'b000;

    p_answer_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sel |=> rsp_valid);

    p_ignore_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> !rsp_valid);

    p_no32_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !cfg_aa32_ok) |=> rsp_kind == 2'b01);

    p_lvl0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && req_el == 2'd0) |=> rsp_kind == 2'b01);

    p_lvl1_trap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && cfg_aa32_ok && req_el == 2'd1 && cfg_nv_trap)
        |=> (rsp_kind == 2'b10 && rsp_target == 2'd2 && rsp_class == 8'h18));

    p_prio_undef_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && cfg_aa32_ok && req_el == 2'd2 && cfg_has_mon && cfg_tda && cfg_sdd_prio)
        |=> rsp_kind == 2'b01);

    p_mon_trap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && cfg_aa32_ok && req_el == 2'd2 && cfg_has_mon && cfg_tda &&
         !cfg_sdd_prio && !cfg_sdd_undef)
        |=> (rsp_kind == 2'b10 && rsp_target == 2'd3 && rsp_class == 8'h18));

    p_lvl3_access_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && cfg_aa32_ok && req_el == 2'd3) |=> rsp_kind == 2'b00);

    p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_rdata[63:32] == 32'h0);

    p_quiet_fields_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind != 2'b10) |-> (rsp_target == 2'd0 && rsp_class == 8'h00));
endmodule

bind vc_sysreg_gate vc_sysreg_gate_chk u_chk (.*);

// File: tb/tb_vc_sysreg_gate.sv
module tb_vc_sysreg_gate;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op0 = '0;
    logic [2:0]  req_op1 = '0;
    logic [3:0]  req_crn = '0;
    logic [3:0]  req_crm = '0;
    logic [2:0]  req_op2 = '0;
    logic        req_write = 1'b0;
    logic [1:0]  req_el = '0;
    logic [63:0] req_wdata = '0;
    logic        cfg_aa32_ok = 1'b0;
    logic        cfg_nv_trap = 1'b0;
    logic        cfg_has_mon = 1'b0;
    logic        cfg_tda = 1'b0;
    logic        cfg_sdd_prio = 1'b0;
    logic        cfg_sdd_undef = 1'b0;
    logic        rsp_valid;
    logic [1:0]  rsp_kind;
    logic [1:0]  rsp_target;
    logic [7:0]  rsp_class;
    logic [63:0] rsp_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    logic [63:0] model = '0;
    localparam logic [15:0] KEY = 16'b10_100_0000_0111_000;

    vc_sysreg_gate dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [76:0] act, input logic [76:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // returns {kind,target,class}
    function automatic logic [11:0] expect_out(input logic [1:0] el, input logic [5:0] c);
        logic aa, nv, mon, tda, pr, su;
        {su, pr, tda, mon, nv, aa} = c;
        if (!aa) return {2'b01, 2'd0, 8'h00};
        case (el)
            2'd0: return {2'b01, 2'd0, 8'h00};
            2'd1: return nv ? {2'b10, 2'd2, 8'h18} : {2'b01, 2'd0, 8'h00};
            2'd2: begin
                if (mon && tda && pr) return {2'b01, 2'd0, 8'h00};
                if (mon && tda) return su ? {2'b01, 2'd0, 8'h00} : {2'b10, 2'd3, 8'h18};
                return {2'b00, 2'd0, 8'h00};
            end
            default: return {2'b00, 2'd0, 8'h00};
        endcase
    endfunction

    function automatic string tag_for(input logic [1:0] el, input logic [5:0] c);
        if (!c[0]) return "R2";
        case (el)
            2'd0: return "R3";
            2'd1: return "R4";
            2'd2: return (c[2] && c[3]) ? (c[4] ? "R5" : "R6") : "R7";
            default: return "R7";
        endcase
    endfunction

    task automatic drive(input logic [15:0] enc, input logic wr, input logic [1:0] el,
                         input logic [5:0] c, input logic [63:0] wd);
        @(negedge clk);
        req_valid = 1'b1;
        {req_op0, req_op1, req_crn, req_crm, req_op2} = enc;
        req_write = wr;
        req_el = el;
        req_wdata = wd;
        {cfg_sdd_undef, cfg_sdd_prio, cfg_tda, cfg_has_mon, cfg_nv_trap, cfg_aa32_ok} = c;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic access(input logic wr, input logic [1:0] el, input logic [5:0] c,
                          input logic [63:0] wd);
        logic [11:0] e;
        logic [63:0] erd;
        e = expect_out(el, c);
        erd = (!wr && e[11:10] == 2'b00) ? model : 64'h0;
        drive(KEY, wr, el, c, wd);
        check(tag_for(el, c), {1'b1, rsp_kind, rsp_target, rsp_class, rsp_rdata},
              {1'b1, e, erd});
        check("R9", {76'h0, rsp_valid}, {76'h0, 1'b1});
        if (wr && e[11:10] == 2'b00) model = {32'h0, wd[31:0]};
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: idle after reset, stored value zero
        check("R10", {76'h0, rsp_valid}, 77'h0);
        access(1'b0, 2'd3, 6'b000001, 64'h0);
        check("R10", {13'h0, rsp_rdata}, 77'h0);

        // exhaustive sweep: level x configuration, write then read
        for (int i = 0; i < 256; i++) begin
            logic [1:0] el;
            logic [5:0] c;
            logic [63:0] wd;
            el = i[1:0];
            c = i[7:2];
            wd = {32'hFFFF_0000 | 32'(i), 32'h1357_0000 + 32'(i) * 32'h0000_0101 + 32'h1};
            access(1'b1, el, c, wd);
            access(1'b0, el, c, 64'h0);
            // R8: readback at level 3 exposes whether the write landed and upper bits dropped
            access(1'b0, 2'd3, 6'b000001, 64'h0);
            check("R8", {13'h0, rsp_rdata}, {13'h0, model});
            @(negedge clk);
            check("R9", {76'h0, rsp_valid}, 77'h0);
        end

        // R1: single-bit corrupted encodings at level 3 are ignored
        for (int b = 0; b < 16; b++) begin
            drive(KEY ^ (16'h1 << b), 1'b1, 2'd3, 6'b000001, 64'h0BAD_0BAD_CAFE_F00D);
            check("R1", {76'h0, rsp_valid}, 77'h0);
        end
        access(1'b0, 2'd3, 6'b000001, 64'h0);
        check("R1", {13'h0, rsp_rdata}, {13'h0, model});

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule